// File: doc/BRIEF.md
# Serial DAC Word Loader

This block takes 16-bit words from a three-wire serial link and holds the 14-bit code that drives a digital-to-analog converter. The three wires are an active-low select, a serial clock and a data line. All logic runs on a fast system clock. The three serial inputs are each brought into that clock through a two-flop synchronizer, and their edges are found in the system clock domain. The system clock must run at least four times as fast as the serial clock.

A word is shifted in, most significant bit first, while select is low. The word holds fourteen code bits followed by two trailing sub-bits. The code moves into the output latch only when select returns high, and only if exactly sixteen serial clock rising edges were counted while select was low. Any other count leaves the latch alone and raises an error pulse.

An active-low clear input forces the latch to a preset code without waiting for a clock edge. The preset is also loaded at reset. The end of a clear is synchronized to the system clock, so the latch leaves the preset cleanly on a clock edge. The preset depends on a mode parameter: zero for unipolar, and midscale for bipolar, where the code is offset binary.

Top module: `dac_serial_loader`

## Requirements
- R1: While `sel_n` is low, one bit of `sdi` is captured on each rising edge of `sck`, most significant bit first. In a valid frame the first fourteen bits captured become `dac_code[13:0]`, with the first bit at bit 13.
- R2: `dac_code` changes only after `sel_n` rises, and never on a `sck` edge. The new value appears in the same system clock cycle as `load_pulse`, and within five system clocks after the rise of `sel_n`. `load_pulse` is high for exactly one cycle for each valid frame.
- R3: If the number of `sck` rising edges counted while `sel_n` was low is anything other than 16, `dac_code` keeps its value when `sel_n` rises, `load_pulse` stays low, and `frame_err` is high for one cycle.
- R4: The last two bits of a frame (the sub-bits) never reach `dac_code`. A valid frame sets `sub_flag` to 1 if either sub-bit is 1, and to 0 if both are 0. Invalid frames do not change `sub_flag`.
- R5: While `clr_n` is low, `dac_code` holds the preset code. The preset is forced at once, before any clock edge, whatever the serial lines are doing.
- R6: After `clr_n` is released, `dac_code` keeps the preset code until the next valid frame completes. A frame that ends after the release loads normally, even if `clr_n` was pulsed while that frame was being shifted in.
- R7: The preset code is 0 when BIPOLAR=0 and 0x2000 when BIPOLAR=1. While `rst_n` is low, `dac_code` holds the preset and `load_pulse`, `frame_err` and `sub_flag` are 0.
- R8: Every falling edge of `sel_n` restarts the bit count and the shift register. A complete frame that follows a partial frame therefore loads its own code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_n | input | 1 | Active-low asynchronous clear of the code latch |
| sel_n | input | 1 | Serial select, active low, frames a word |
| sck | input | 1 | Serial clock; data is captured on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| dac_code | output | 14 | Latched converter code |
| load_pulse | output | 1 | One-cycle strobe when a new code is latched |
| frame_err | output | 1 | One-cycle strobe when a frame had the wrong bit count |
| sub_flag | output | 1 | Set by a valid frame with a nonzero sub-bit, cleared by a valid frame with both sub-bits zero |

## Verification
The assertions check on every cycle that `load_pulse` lasts one cycle and never comes with `frame_err`, that `dac_code` moves only together with `load_pulse` or a clear, that a low `clr_n` always shows the preset code, and that `sub_flag` changes only when a code is loaded. What a frame actually loads cannot be judged cycle by cycle. Bit order, the choice of which fourteen bits are kept, the rejection of short and long frames, recovery after a partial frame, and a clear pulse in the middle of a transfer are shown only by the bench. The bench sends serial words and compares each strobe against the value it predicted.

// File: rtl/dacser_pkg.sv
package dacser_pkg;

  // Preset code for the latch: midscale when bipolar, zero otherwise.
  function automatic int unsigned preset_value(input bit bipolar, input int unsigned width);
    return bipolar ? (32'd1 << (width - 1)) : 32'd0;
  endfunction

  // A frame is complete only when the counted edges match the frame length.
  function automatic bit frame_complete(input int unsigned counted, input int unsigned frame_len);
    return counted == frame_len;
  endfunction

  // Any set sub-bit is reported.
  function automatic bit sub_nonzero(input logic [7:0] subs);
    return subs != 8'd0;
  endfunction

endpackage

// File: rtl/dacser_sync.sv
module dacser_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacser_frame.sv
module dacser_frame
  import dacser_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              sel_s,
  input  logic              sdi_s,
  output logic              frame_ok,
  output logic              frame_bad,
  output logic [DATA_W-1:0] word_data,
  output logic [SUB_W-1:0]  word_sub
);
  localparam int unsigned FB      = DATA_W + SUB_W;
  localparam int unsigned CW      = $clog2(FB + 2);
  localparam logic [CW-1:0] CNT_SAT = CW'(FB + 1);

  logic          p_sck, p_sel;
  logic [CW-1:0] cnt;
  logic [FB-1:0] sr;
  logic          sel_fall, sel_rise, sck_rise;

  assign sel_fall = p_sel & ~sel_s;
  assign sel_rise = ~p_sel & sel_s;
  assign sck_rise = sck_s & ~p_sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sck <= 1'b0;
      p_sel <= 1'b1;
      cnt   <= '0;
      sr    <= '0;
    end else begin
      p_sck <= sck_s;
      p_sel <= sel_s;
      if (sel_fall) begin
        cnt <= '0;
        sr  <= '0;
      end else if (!sel_s && sck_rise) begin
        sr <= {sr[FB-2:0], sdi_s};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame_ok  = sel_rise && frame_complete(32'(cnt), FB);
  assign frame_bad = sel_rise && !frame_complete(32'(cnt), FB);
  assign word_data = sr[FB-1:SUB_W];
  assign word_sub  = sr[SUB_W-1:0];
endmodule

// File: rtl/dacser_clrsync.sv
module dacser_clrsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic latch_rst_n
);
  logic       any_n;
  logic [STAGES-1:0] chain;

  assign any_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge any_n) begin
    if (!any_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign latch_rst_n = chain[STAGES-1];
endmodule

// File: rtl/dacser_latch.sv
module dacser_latch
  import dacser_pkg::*;
#(
  parameter int unsigned DATA_W  = 14,
  parameter int unsigned SUB_W   = 2,
  parameter bit          BIPOLAR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_rst_n,
  input  logic              load,
  input  logic              bad,
  input  logic [DATA_W-1:0] data,
  input  logic [SUB_W-1:0]  sub,
  output logic [DATA_W-1:0] code,
  output logic              load_pulse,
  output logic              err_pulse,
  output logic              sub_flag
);
  localparam logic [DATA_W-1:0] PRESET = DATA_W'(preset_value(BIPOLAR, DATA_W));

  logic load_eff;
  assign load_eff = load & latch_rst_n;

  always_ff @(posedge clk or negedge latch_rst_n) begin
    if (!latch_rst_n)  code <= PRESET;
    else if (load)     code <= data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      sub_flag   <= 1'b0;
    end else begin
      load_pulse <= load_eff;
      err_pulse  <= bad;
      if (load_eff) sub_flag <= sub_nonzero(8'(sub));
    end
  end
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader #(
  parameter int unsigned DATA_W      = 14,
  parameter int unsigned SUB_W       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          BIPOLAR     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              sdi,
  output logic [DATA_W-1:0] dac_code,
  output logic              load_pulse,
  output logic              frame_err,
  output logic              sub_flag
);
  // Synchronized serial lines: {sel, sck, sdi}; idle select is high.
  logic [2:0] raw_lines, sync_lines;
  logic       sel_s, sck_s, sdi_s;
  logic       frame_ok, frame_bad;
  logic       latch_rst_n;
  logic [DATA_W-1:0] word_data;
  logic [SUB_W-1:0]  word_sub;

  assign raw_lines = {sel_n, sck, sdi};

  dacser_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .IDLE(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
  );

  assign {sel_s, sck_s, sdi_s} = sync_lines;

  dacser_frame #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .sel_s(sel_s), .sdi_s(sdi_s),
    .frame_ok(frame_ok), .frame_bad(frame_bad),
    .word_data(word_data), .word_sub(word_sub)
  );

  dacser_clrsync #(.STAGES(SYNC_STAGES)) u_clr (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .latch_rst_n(latch_rst_n)
  );

  dacser_latch #(.DATA_W(DATA_W), .SUB_W(SUB_W), .BIPOLAR(BIPOLAR)) u_latch (
    .clk(clk), .rst_n(rst_n), .latch_rst_n(latch_rst_n),
    .load(frame_ok), .bad(frame_bad), .data(word_data), .sub(word_sub),
    .code(dac_code), .load_pulse(load_pulse), .err_pulse(frame_err),
    .sub_flag(sub_flag)
  );
endmodule

// File: rtl/dac_serial_loader_chk.sv
module dac_serial_loader_chk
  import dacser_pkg::*;
#(
  parameter int unsigned DATA_W  = 14,
  parameter bit          BIPOLAR = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic [DATA_W-1:0] dac_code,
  input logic              load_pulse,
  input logic              frame_err,
  input logic              sub_flag
);
  localparam logic [DATA_W-1:0] PRESET = DATA_W'(preset_value(BIPOLAR, DATA_W));

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse); // R2

  AST_ERR_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_pulse && frame_err)); // R3

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_pulse && clr_n && $past(clr_n)) |-> $stable(dac_code)); // R2

  AST_ERR_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && clr_n && $past(clr_n)) |-> $stable(dac_code)); // R3

  AST_CLEAR_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_code == PRESET); // R5

  AST_FLAG_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |-> $stable(sub_flag)); // R4
endmodule

bind dac_serial_loader dac_serial_loader_chk #(.DATA_W(DATA_W), .BIPOLAR(BIPOLAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .dac_code(dac_code),
  .load_pulse(load_pulse), .frame_err(frame_err), .sub_flag(sub_flag)
);

// File: tb/tb_dac_serial_loader.sv
`timescale 1ns/1ps
module tb_dac_serial_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1;
  logic sel_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic [13:0] code_b, code_u;
  logic load_b, load_u, err_b, err_u, flag_b, flag_u;

  always #5 clk = ~clk;

  dac_serial_loader #(.BIPOLAR(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .dac_code(code_b), .load_pulse(load_b), .frame_err(err_b), .sub_flag(flag_b)
  );

  dac_serial_loader #(.BIPOLAR(1'b0)) dut_u (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .dac_code(code_u), .load_pulse(load_u), .frame_err(err_u), .sub_flag(flag_u)
  );

  typedef struct {
    bit          is_load;
    logic [13:0] code;
    logic        flag;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [13:0] model_code = 14'h2000;
  logic        model_flag = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Driver: predicts the result, queues it, then shifts the word out.
  task automatic send(input logic [15:0] w, input int nbits, input string tag);
    exp_t e;
    e.tag = tag;
    if (nbits == 16) begin
      e.is_load  = 1;
      model_code = w[15:2];
      model_flag = (w[1:0] != 2'b00);
    end else begin
      e.is_load = 0;
    end
    e.code = model_code;
    e.flag = model_flag;
    exp_q.push_back(e);
    @(negedge clk); sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15 - i] : 1'b0;
      repeat (3) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk); sel_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // Monitor: pops a prediction for each strobe the design produces.
  always @(negedge clk) begin
    if (rst_n && (load_b || err_b)) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected strobe", {30'd0, load_b, err_b}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(load_b == e.is_load && err_b == !e.is_load,
              {e.tag, " strobe kind"}, {31'd0, load_b}, {31'd0, e.is_load});
        check(code_b == e.code, {e.tag, " code"}, 32'(code_b), 32'(e.code));
        check(flag_b == e.flag, {e.tag, " sub_flag"}, 32'(flag_b), 32'(e.flag));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R7: reset state of both modes
    check(code_b == 14'h2000, "R7 bipolar reset code", 32'(code_b), 32'h2000);
    check(code_u == 14'h0000, "R7 unipolar reset code", 32'(code_u), 0);
    check(!load_b && !err_b && !flag_b, "R7 reset strobes", {29'd0, load_b, err_b, flag_b}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    send({14'h1234, 2'b00}, 16, "R1 word 1234");
    send({14'h3FFF, 2'b00}, 16, "R1 all ones");
    send({14'h0000, 2'b00}, 16, "R1 all zeros");
    send({14'h2A55, 2'b01}, 16, "R4 nonzero sub-bit");
    send({14'h1111, 2'b00}, 10, "R3 short frame");
    send({14'h0F0F, 2'b11}, 17, "R3 long frame");
    send({14'h0ABC, 2'b00}, 16, "R8 frame after partial");
    send({14'h1555, 2'b10}, 16, "R4 upper sub-bit set");
    send({14'h1555, 2'b00}, 16, "R4 sub_flag cleared");
    check(code_u == 14'h1555, "R1 unipolar copy loads", 32'(code_u), 32'h1555);

    // R5: clear forces preset immediately
    @(negedge clk); clr_n = 1'b0; #1;
    check(code_b == 14'h2000, "R5 bipolar clear immediate", 32'(code_b), 32'h2000);
    check(code_u == 14'h0000, "R5 unipolar clear immediate", 32'(code_u), 0);
    repeat (6) @(negedge clk);
    check(code_b == 14'h2000, "R5 clear held", 32'(code_b), 32'h2000);
    clr_n = 1'b1;
    model_code = 14'h2000;
    repeat (10) @(negedge clk);
    check(code_b == 14'h2000, "R6 preset after release", 32'(code_b), 32'h2000);
    check(!load_b && !err_b, "R6 no strobe after release", {30'd0, load_b, err_b}, 0);
    send({14'h0777, 2'b00}, 16, "R6 load after clear");

    // R6: a clear pulse in the middle of a transfer
    fork
      send({14'h3210, 2'b00}, 16, "R6 frame across clear");
      begin
        repeat (30) @(negedge clk); clr_n = 1'b0; #1;
        check(code_b == 14'h2000, "R5 clear during frame", 32'(code_b), 32'h2000);
        repeat (4) @(negedge clk); clr_n = 1'b1;
      end
    join
    check(code_u == 14'h3210, "R6 unipolar after mid-frame clear", 32'(code_u), 32'h3210);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2 every frame produced a strobe", exp_q.size(), 0);
    finish_run();
  end
endmodule